// File: doc/BRIEF.md
# Packed-word to display pixel format converter

This block sits between a word-wide pixel buffer and a parallel display pixel bus. It takes one packed word (64 bits by default) at a time and turns it into a sequence of RGB pixels, one per clock, on a valid/ready stream. The word may hold RGB pixels or YUV 4:2:2 pixels. For YUV, the block handles four component byte orders and an optional reversed pixel order. It converts the samples to RGB using either the standard-definition or the high-definition matrix.

Static configuration inputs choose the input kind, the output depth, the YUV byte order, the pixel order and the colour matrix. These inputs must stay constant while a word is in flight. The output is always a 24-bit bus. The narrower depths are right-aligned on it, and the unused upper bits are driven to zero. Each pair of YUV pixels shares its one chroma sample. No interpolation is done.

Top module: `pix_fmt_conv`

## Requirements
- R1: During and directly after reset, out_valid is 0 and in_ready is 1.
- R2: While out_valid is 1 and out_ready is 0, out_pix holds its value and out_valid stays 1. Each accepted word yields exactly its pixel count, in order, and no extra pixel. With both sides always ready, the block delivers one pixel per cycle without gaps across word boundaries.
- R3: With cfg_yuv=0 and cfg_fmt other than 2, the word holds 32-bit slots, and the lowest slot is emitted first. In each slot, red is bits [23:16], green is bits [15:8] and blue is bits [7:0]. Bits [31:24] are ignored.
- R4: With cfg_yuv=0 and cfg_fmt=2, the word holds 16-bit slots, and the lowest slot is emitted first. In each slot, red is [15:11], green is [10:5] and blue is [4:0]. Each field is widened to 8 bits with zero low bits.
- R5: The cfg_fmt codes set the output layout. Code 0 gives {R,G,B}. Code 1 gives {6'b0,R[7:2],G[7:2],B[7:2]}. Code 2 gives {8'b0,R[7:3],G[7:2],B[7:3]}. Codes 3 to 15 behave as code 0.
- R6: With cfg_yuv=1, each 32-bit group carries two pixels, and byte 0 is the least significant byte. The cfg_order codes give the byte order. Code 0 gives Y0,U,Y1,V. Code 1 gives Y0,V,Y1,U. Code 2 gives U,Y0,V,Y1. Code 3 gives V,Y0,U,Y1.
- R7: With cfg_rev=0, the YUV pixels are emitted as group 0 pixel 0, group 0 pixel 1, group 1 pixel 0, group 1 pixel 1. With cfg_rev=1, the same four are emitted in reverse order. Both pixels of a group use that group's U and V.
- R8: With cfg_bt709=0, let C=Y-16, D=U-128 and E=V-128. Then R=(298C+409E+128)>>8, G=(298C-100D-208E+128)>>8 and B=(298C+516D+128)>>8, where >> is an arithmetic (floor) shift.
- R9: With cfg_bt709=1, the coefficients become 459 for E in R, -55 for D and -136 for E in G, and 541 for D in B. The 298 term and the rounding are the same as in R8.
- R10: Each converted component saturates to the range 0 to 255 before the output depth truncates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 4 | Output depth code (0 888, 1 666, 2 565) |
| cfg_yuv | input | 1 | 0 RGB words, 1 YUV 4:2:2 words |
| cfg_order | input | 2 | YUV byte order code |
| cfg_rev | input | 1 | Reverse YUV pixel order within a word |
| cfg_bt709 | input | 1 | 0 standard-definition matrix, 1 high-definition matrix |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | WORD_W | Packed pixel word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink takes the pixel |
| out_pix | output | 24 | Packed RGB pixel |

## Verification
The bench builds the block with the default WORD_W of 64. With that width, a word carries two 32-bit RGB slots or four 16-bit and YUV slots, so the 2-bit slot index reaches its last value on every YUV and 565 word. Random stall patterns on both sides put word boundaries under backpressure. All 16 combinations of byte order, reversal and matrix run on random words, and directed words drive the results to both saturation limits.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int COMP_W = 8;
    localparam int ACC_W  = 20;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    typedef enum logic [3:0] {
        FMT_888 = 4'd0,
        FMT_666 = 4'd1,
        FMT_565 = 4'd2
    } out_fmt_e;

    typedef enum logic [1:0] {
        ORD_YUYV = 2'd0,
        ORD_YVYU = 2'd1,
        ORD_UYVY = 2'd2,
        ORD_VYUY = 2'd3
    } yuv_order_e;

    // matrix weights, 8 fractional bits
    localparam int K_LUMA    = 298;
    localparam int K_RV_SD   = 409;
    localparam int K_GU_SD   = 100;
    localparam int K_GV_SD   = 208;
    localparam int K_BU_SD   = 516;
    localparam int K_RV_HD   = 459;
    localparam int K_GU_HD   = 55;
    localparam int K_GV_HD   = 136;
    localparam int K_BU_HD   = 541;
    localparam int K_ROUND   = 128;

    function automatic logic [COMP_W-1:0] clamp_comp(input logic signed [ACC_W-1:0] acc);
        logic [COMP_W-1:0] res;
        if (acc[ACC_W-1]) begin
            res = '0;
        end else if (|acc[ACC_W-2:16]) begin
            res = '1;
        end else begin
            res = acc[15:8];
        end
        return res;
    endfunction

endpackage

// File: rtl/pfc_unpack.sv
module pfc_unpack
    import pfc_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int IDX_W  = $clog2(WORD_W/16)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  logic              narrow_rgb,
    input  logic [1:0]        order,
    input  logic              rev,
    output rgb_t              rgb_raw,
    output logic [COMP_W-1:0] y_s,
    output logic [COMP_W-1:0] u_s,
    output logic [COMP_W-1:0] v_s
);

    localparam int N16 = WORD_W / 16;
    localparam int N32 = WORD_W / 32;
    localparam int GW  = $clog2(N32);

    logic [15:0] half_w [N16];
    logic [31:0] grp_w  [N32];

    for (genvar i = 0; i < N16; i++) begin : g_half
        assign half_w[i] = word[16*i +: 16];
    end
    for (genvar j = 0; j < N32; j++) begin : g_grp
        assign grp_w[j] = word[32*j +: 32];
    end

    logic [IDX_W-1:0] slot;
    logic [IDX_W-1:0] gsel;
    logic [31:0]      yg;
    logic [7:0]       bt [4];
    logic [7:0]       y0, y1;

    always_comb begin
        slot = rev ? (IDX_W'(N16 - 1) - idx) : idx;
        gsel = slot >> 1;
        yg   = grp_w[gsel[GW-1:0]];
        for (int k = 0; k < 4; k++) begin
            bt[k] = yg[8*k +: 8];
        end
        case (order)
            ORD_YUYV: begin y0 = bt[0]; u_s = bt[1]; y1 = bt[2]; v_s = bt[3]; end
            ORD_YVYU: begin y0 = bt[0]; v_s = bt[1]; y1 = bt[2]; u_s = bt[3]; end
            ORD_UYVY: begin u_s = bt[0]; y0 = bt[1]; v_s = bt[2]; y1 = bt[3]; end
            default:  begin v_s = bt[0]; y0 = bt[1]; u_s = bt[2]; y1 = bt[3]; end
        endcase
        y_s = slot[0] ? y1 : y0;
    end

    logic [15:0] hw;
    logic [31:0] ww;

    always_comb begin
        hw = half_w[idx];
        ww = grp_w[idx[GW-1:0]];
        if (narrow_rgb) begin
            rgb_raw.r = {hw[15:11], 3'b000};
            rgb_raw.g = {hw[10:5],  2'b00};
            rgb_raw.b = {hw[4:0],   3'b000};
        end else begin
            rgb_raw.r = ww[23:16];
            rgb_raw.g = ww[15:8];
            rgb_raw.b = ww[7:0];
        end
    end

endmodule

// File: rtl/pfc_csc.sv
module pfc_csc
    import pfc_pkg::*;
(
    input  logic [COMP_W-1:0] y_s,
    input  logic [COMP_W-1:0] u_s,
    input  logic [COMP_W-1:0] v_s,
    input  logic              hd,
    output rgb_t              rgb
);

    logic signed [ACC_W-1:0] c_t, d_t, e_t;
    logic signed [ACC_W-1:0] k_rv, k_gu, k_gv, k_bu;
    logic signed [ACC_W-1:0] luma, acc_r, acc_g, acc_b;

    always_comb begin
        c_t = $signed({{(ACC_W-COMP_W){1'b0}}, y_s}) - ACC_W'(16);
        d_t = $signed({{(ACC_W-COMP_W){1'b0}}, u_s}) - ACC_W'(128);
        e_t = $signed({{(ACC_W-COMP_W){1'b0}}, v_s}) - ACC_W'(128);
        k_rv = hd ? ACC_W'(K_RV_HD) : ACC_W'(K_RV_SD);
        k_gu = hd ? ACC_W'(K_GU_HD) : ACC_W'(K_GU_SD);
        k_gv = hd ? ACC_W'(K_GV_HD) : ACC_W'(K_GV_SD);
        k_bu = hd ? ACC_W'(K_BU_HD) : ACC_W'(K_BU_SD);
        luma  = ACC_W'(K_LUMA) * c_t + ACC_W'(K_ROUND);
        acc_r = luma + k_rv * e_t;
        acc_g = luma - k_gu * d_t - k_gv * e_t;
        acc_b = luma + k_bu * d_t;
        rgb.r = clamp_comp(acc_r);
        rgb.g = clamp_comp(acc_g);
        rgb.b = clamp_comp(acc_b);
    end

endmodule

// File: rtl/pfc_pack.sv
module pfc_pack
    import pfc_pkg::*;
(
    input  rgb_t        rgb,
    input  logic [3:0]  fmt,
    output logic [3*COMP_W-1:0] pix
);

    always_comb begin
        case (fmt)
            FMT_666: pix = {6'd0, rgb.r[7:2], rgb.g[7:2], rgb.b[7:2]};
            FMT_565: pix = {8'd0, rgb.r[7:3], rgb.g[7:2], rgb.b[7:3]};
            default: pix = {rgb.r, rgb.g, rgb.b};
        endcase
    end

endmodule

// File: rtl/pix_fmt_conv.sv
module pix_fmt_conv
    import pfc_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_fmt,
    input  logic              cfg_yuv,
    input  logic [1:0]        cfg_order,
    input  logic              cfg_rev,
    input  logic              cfg_bt709,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_pix
);

    localparam int N16   = WORD_W / 16;
    localparam int N32   = WORD_W / 32;
    localparam int IDX_W = $clog2(N16);
    localparam int PIX_W = 3 * COMP_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              word_vld;
        logic [IDX_W-1:0]  idx;
        logic              out_vld;
        logic [PIX_W-1:0]  pix;
    } state_t;

    state_t st_d, st_q;

    logic              narrow_rgb;
    logic [IDX_W-1:0]  last_idx;
    rgb_t              raw_rgb, yuv_rgb, sel_rgb;
    logic [COMP_W-1:0] y_s, u_s, v_s;
    logic [PIX_W-1:0]  packed_pix;
    logic              advance, at_last;
    logic              word_held;

    assign narrow_rgb = (cfg_fmt == FMT_565);
    assign last_idx   = (cfg_yuv || narrow_rgb) ? IDX_W'(N16 - 1) : IDX_W'(N32 - 1);

    pfc_unpack #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_unpack (
        .word       (st_q.word),
        .idx        (st_q.idx),
        .narrow_rgb (narrow_rgb),
        .order      (cfg_order),
        .rev        (cfg_rev),
        .rgb_raw    (raw_rgb),
        .y_s        (y_s),
        .u_s        (u_s),
        .v_s        (v_s)
    );

    pfc_csc i_csc (
        .y_s (y_s),
        .u_s (u_s),
        .v_s (v_s),
        .hd  (cfg_bt709),
        .rgb (yuv_rgb)
    );

    assign sel_rgb = cfg_yuv ? yuv_rgb : raw_rgb;

    pfc_pack i_pack (
        .rgb (sel_rgb),
        .fmt (cfg_fmt),
        .pix (packed_pix)
    );

    assign advance  = st_q.word_vld && (!st_q.out_vld || out_ready);
    assign at_last  = (st_q.idx == last_idx);
    assign in_ready = !st_q.word_vld || (advance && at_last);

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.out_vld = 1'b1;
            st_d.pix     = packed_pix;
            if (at_last) begin
                st_d.word_vld = 1'b0;
                st_d.idx      = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else if (out_ready) begin
            st_d.out_vld = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.word     = in_word;
            st_d.word_vld = 1'b1;
            st_d.idx      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_vld;
    assign out_pix   = st_q.pix;
    assign word_held = st_q.word_vld;

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cfg_fmt,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [23:0] out_pix,
    input logic        word_held
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R2

    AST_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> word_held); // R2

    AST_NARROW_565: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_fmt == 4'd2 |-> out_pix[23:16] == 8'd0); // R5

    AST_NARROW_666: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && cfg_fmt == 4'd1 |-> out_pix[23:18] == 6'd0); // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && in_ready); // R1

endmodule

bind pix_fmt_conv pfc_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .word_held (word_held)
);

// File: tb/test_pix_fmt_conv.sv
module test_pix_fmt_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = '0;
    logic        cfg_yuv = 1'b0;
    logic [1:0]  cfg_order = '0;
    logic        cfg_rev = 1'b0;
    logic        cfg_bt709 = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_pix;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] exp_q[$];
    logic [63:0] wbuf [16];
    logic [23:0] outlog [64];
    int          nlog;
    int          run_cycles;

    always #10 clk = ~clk;

    pix_fmt_conv i_pix_fmt_conv (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_yuv(cfg_yuv),
        .cfg_order(cfg_order), .cfg_rev(cfg_rev), .cfg_bt709(cfg_bt709),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clip(input int a);
        int s = a >>> 8;
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    function automatic int npix();
        return (cfg_yuv || cfg_fmt == 4'd2) ? 4 : 2;
    endfunction

    function automatic logic [23:0] ref_pix(input logic [63:0] w, input int t);
        int r, g, b, s, yv, uv, vv, c, d, e;
        logic [31:0] grp;
        logic [7:0] b0, b1, b2, b3, y0, y1;
        if (!cfg_yuv) begin
            if (cfg_fmt == 4'd2) begin
                r = int'(w[16*t+11 +: 5]) * 8;
                g = int'(w[16*t+5 +: 6]) * 4;
                b = int'(w[16*t +: 5]) * 8;
            end else begin
                r = int'(w[32*t+16 +: 8]);
                g = int'(w[32*t+8 +: 8]);
                b = int'(w[32*t +: 8]);
            end
        end else begin
            s = cfg_rev ? 3 - t : t;
            grp = w[32*(s/2) +: 32];
            b0 = grp[7:0]; b1 = grp[15:8]; b2 = grp[23:16]; b3 = grp[31:24];
            case (cfg_order)
                2'd0: begin y0 = b0; uv = b1; y1 = b2; vv = b3; end
                2'd1: begin y0 = b0; vv = b1; y1 = b2; uv = b3; end
                2'd2: begin uv = b0; y0 = b1; vv = b2; y1 = b3; end
                default: begin vv = b0; y0 = b1; uv = b2; y1 = b3; end
            endcase
            yv = (s % 2 == 1) ? y1 : y0;
            c = yv - 16; d = uv - 128; e = vv - 128;
            if (cfg_bt709) begin
                r = clip(298*c + 459*e + 128);
                g = clip(298*c - 55*d - 136*e + 128);
                b = clip(298*c + 541*d + 128);
            end else begin
                r = clip(298*c + 409*e + 128);
                g = clip(298*c - 100*d - 208*e + 128);
                b = clip(298*c + 516*d + 128);
            end
        end
        case (cfg_fmt)
            4'd1: return {6'd0, 6'(r >> 2), 6'(g >> 2), 6'(b >> 2)};
            4'd2: return {8'd0, 5'(r >> 3), 6'(g >> 2), 5'(b >> 3)};
            default: return {8'(r), 8'(g), 8'(b)};
        endcase
    endfunction

    // streams wbuf[0..n-1]; full=1 keeps both sides always ready
    task automatic run_words(input int n, input bit full, input string req);
        int idx = 0;
        bit hold_pend = 0;
        logic [23:0] hold_pix = '0;
        nlog = 0;
        run_cycles = 0;
        while ((idx < n || exp_q.size() > 0) && run_cycles < 2000) begin
            @(negedge clk);
            in_valid  = (idx < n) && (full || ($urandom % 4 != 0));
            in_word   = wbuf[idx < n ? idx : 0];
            out_ready = full || ($urandom % 3 != 0);
            #5;
            run_cycles++;
            if (in_valid && in_ready) begin
                for (int t = 0; t < npix(); t++) exp_q.push_back(ref_pix(wbuf[idx], t));
                idx++;
            end
            if (hold_pend) begin
                // R2 stall hold
                chk(out_valid && out_pix == hold_pix, "R2", {7'd0, out_valid, out_pix}, {8'h01, hold_pix});
                hold_pend = 0;
            end
            if (out_valid) begin
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R2", {8'd0, out_pix}, 32'hFFFFFFFF);
                    end else begin
                        logic [23:0] ex = exp_q.pop_front();
                        chk(out_pix == ex, req, {8'd0, out_pix}, {8'd0, ex});
                        if (nlog < 64) begin outlog[nlog] = out_pix; nlog++; end
                    end
                end else begin
                    hold_pend = 1;
                    hold_pix  = out_pix;
                end
            end
        end
        @(negedge clk);
        in_valid  = 0;
        out_ready = 1;
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        // R2 no surplus pixel after the stream drains
        for (int k = 0; k < 3; k++) begin
            #5;
            chk(!out_valid, "R2", {31'd0, out_valid}, 0);
            @(negedge clk);
        end
        exp_q.delete();
    endtask

    task automatic rand_words(input int n);
        for (int k = 0; k < n; k++) wbuf[k] = {$urandom, $urandom};
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        #5;
        chk(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1;
        #5;
        chk(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'h1);

        // R3 R5 RGB words, three output depths plus an unused code
        cfg_yuv = 0;
        cfg_fmt = 4'd0; rand_words(12); run_words(12, 0, "R3");
        cfg_fmt = 4'd1; rand_words(12); run_words(12, 0, "R5");
        cfg_fmt = 4'd9; rand_words(12); run_words(12, 0, "R5");
        // R4 565 input slots
        cfg_fmt = 4'd2; rand_words(12); run_words(12, 0, "R4");

        // R6 R7 R8 R9 every byte order, pixel order and matrix
        cfg_yuv = 1;
        for (int m = 0; m < 16; m++) begin
            cfg_order = 2'(m);
            cfg_rev   = m[2];
            cfg_bt709 = m[3];
            cfg_fmt   = 4'(m % 3);
            rand_words(6);
            run_words(6, 0, m[3] ? "R9" : "R8");
        end

        // R10 extreme samples reach both clamps
        cfg_fmt = 0; cfg_order = 0; cfg_rev = 0; cfg_bt709 = 0;
        wbuf[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        wbuf[1] = 64'h0;
        wbuf[2] = 64'hFF00_FF00_00FF_00FF;
        wbuf[3] = 64'h00FF_00FF_FF00_FF00;
        run_words(4, 0, "R10");
        cfg_bt709 = 1;
        run_words(4, 0, "R10");

        // R8 R7 directed: Y 16/235 with neutral chroma gives black then white
        cfg_bt709 = 0; cfg_rev = 0;
        wbuf[0] = 64'h80EB_8010_80EB_8010;
        run_words(1, 1, "R8");
        chk(outlog[0] == 24'h000000, "R8", {8'd0, outlog[0]}, 32'h0);
        chk(outlog[1] == 24'hFFFFFF, "R8", {8'd0, outlog[1]}, 32'hFFFFFF);
        cfg_rev = 1;
        run_words(1, 1, "R7");
        chk(outlog[0] == 24'hFFFFFF, "R7", {8'd0, outlog[0]}, 32'hFFFFFF);
        chk(outlog[3] == 24'h000000, "R7", {8'd0, outlog[3]}, 32'h0);

        // R2 full rate: 8 words of 4 pixels, 32 pixels in 34 sampled cycles
        cfg_yuv = 0; cfg_fmt = 4'd2; cfg_rev = 0;
        rand_words(8);
        run_words(8, 1, "R2");
        chk(run_cycles == 34, "R2", run_cycles, 34);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule